// File: doc/BRIEF.md
# Second-Source Operand Resolver

This block turns the 8-bit second-source selector of an ALU operation into a 64-bit operand value. The selector can name a register in one of three banks: the rotating part of the procedure stack, the windowed part of the procedure stack, or the global bank. It can also carry a small unsigned constant, or point at one of four 32-bit literal words that travel with the instruction. A literal reference can take a 16-bit half of a word, a whole word, or two adjacent words joined as a 64-bit pair.

For a register selector, the block sends a read request to an external register file in the same cycle and captures the returned data. For any other selector, it builds the value itself. Each result leaves the block one clock after the input strobe. The result carries a kind tag and the register index when a register was named. It also carries an error flag for selectors that name nothing and for literal references to words that are not present.

The output side is a two-state machine. `ST_IDLE` means no result is shown and `ST_SHOW` means a result is shown for one cycle. The transition `IDLE->SHOW` or `SHOW->SHOW` is taken on every cycle with `in_valid` high. The transition `SHOW->IDLE` or `IDLE->IDLE` is taken on every cycle without it.

Top module: `opnd_src_resolver`

## Requirements
- R1: After reset, `out_valid`, `out_err` and `out_data` are all zero.
- R2: A strobe on `in_valid` gives `out_valid` high in exactly the following cycle. A cycle without a strobe gives `out_valid` low in the following cycle.
- R3: Selectors 0x00–0x7F give kind 0 (rotating) with index = selector[6:0]. Selectors 0x80–0xBF give kind 1 (windowed) with index = selector[5:0]. In both cases `rf_rd_en` rises in the strobe cycle and `out_data` is the `rf_rd_data` of that cycle.
- R4: Selectors 0xE0–0xFF give kind 2 (global) with index = selector[4:0], read through the same register-file request.
- R5: Selectors 0xC0–0xCF give kind 3 with `out_data` = selector[3:0], zero-extended.
- R6: Selectors 0xD0/0xD1 take bits 15:0 of literal word 0/1. Selectors 0xD4/0xD5 take bits 31:16 of literal word 0/1. The 16 bits are sign-extended to 64, and the kind is 4 (literal). Word n occupies `lit_words[32n+31:32n]`.
- R7: Selectors 0xD8–0xDB give literal word 0–3, zero-extended to 64 bits, with kind 4.
- R8: Selectors 0xDC, 0xDD and 0xDE give {word1,word0}, {word2,word1} and {word3,word2} respectively, with the higher-numbered word in bits 63:32 and kind 4.
- R9: Selectors 0xD2, 0xD3, 0xD6, 0xD7 and 0xDF set `out_err` and give `out_data` = 0, kind 7 and index 0. They make no register-file request.
- R10: A literal reference whose word has a clear bit in `lit_ok` sets `out_err` and gives `out_data` = 0 and kind 7. A pair needs the `lit_ok` bits of both of its words.
- R11: Register and constant selectors ignore `lit_ok`. A cleared flag gives no error for them.
- R12: The index output is 0 for every non-register result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Selector strobe |
| src_code | input | 8 | Second-source selector |
| lit_words | input | 128 | Four literal words, word n at bits 32n+31:32n |
| lit_ok | input | 4 | Presence flag for each literal word |
| rf_rd_en | output | 1 | Register-file read request |
| rf_rd_kind | output | 3 | Bank of the requested register (0 rotating, 1 windowed, 2 global) |
| rf_rd_idx | output | 7 | Index of the requested register |
| rf_rd_data | input | 64 | Register-file read data, same cycle |
| out_valid | output | 1 | Result present |
| out_data | output | 64 | Resolved operand |
| out_kind | output | 3 | 0 rot, 1 win, 2 glb, 3 const, 4 literal, 7 error |
| out_idx | output | 7 | Register index, or 0 |
| out_err | output | 1 | Selector error |

## Verification
Pair selection and the presence check act in the same cycle on two different words. This means a pair can fail because of its upper word even when its lower word is present. The bench provokes this by clearing only the flag of word 3 for selector 0xDE, and only the flag of word 0 for selector 0xDC. A correct design must report an error with zero data in both cases. A design that checks only the lower word passes the 0xDC case but is caught by the 0xDE case.

// File: rtl/opnd_src_pkg.sv
package opnd_src_pkg;

    typedef enum logic [2:0] {
        K_ROT   = 3'd0,
        K_WIN   = 3'd1,
        K_GLB   = 3'd2,
        K_CONST = 3'd3,
        K_LIT   = 3'd4,
        K_BAD   = 3'd7
    } opnd_kind_e;

    typedef enum logic [2:0] {
        C_REG,
        C_CONST,
        C_HALF_LO,
        C_HALF_HI,
        C_WORD,
        C_PAIR,
        C_BAD
    } opnd_class_e;

    typedef enum logic {
        ST_IDLE,
        ST_SHOW
    } out_state_e;

endpackage

// File: rtl/opnd_src_classify.sv
module opnd_src_classify
    import opnd_src_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int IDX_W  = 7,
    parameter int SEL_W  = 2
) (
    input  logic [CODE_W-1:0] code,
    output opnd_class_e       cls,
    output opnd_kind_e        kind,
    output logic [IDX_W-1:0]  idx,
    output logic [SEL_W-1:0]  wsel
);

    always_comb begin
        cls  = C_BAD;
        kind = K_BAD;
        idx  = '0;
        wsel = '0;
        unique casez (code)
            8'b0???????: begin
                cls  = C_REG;
                kind = K_ROT;
                idx  = code[6:0];
            end
            8'b10??????: begin
                cls  = C_REG;
                kind = K_WIN;
                idx  = {1'b0, code[5:0]};
            end
            8'b111?????: begin
                cls  = C_REG;
                kind = K_GLB;
                idx  = {2'b00, code[4:0]};
            end
            8'b1100????: begin
                cls  = C_CONST;
                kind = K_CONST;
            end
            8'b1101000?: begin
                cls  = C_HALF_LO;
                kind = K_LIT;
                wsel = {1'b0, code[0]};
            end
            8'b1101010?: begin
                cls  = C_HALF_HI;
                kind = K_LIT;
                wsel = {1'b0, code[0]};
            end
            8'b110110??: begin
                cls  = C_WORD;
                kind = K_LIT;
                wsel = code[1:0];
            end
            8'b110111??: begin
                if (code[1:0] != 2'b11) begin
                    cls  = C_PAIR;
                    kind = K_LIT;
                    wsel = code[1:0];
                end
            end
            default: begin
                cls  = C_BAD;
                kind = K_BAD;
            end
        endcase
    end

endmodule

// File: rtl/opnd_src_literal.sv
module opnd_src_literal
    import opnd_src_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int LIT_WORDS = 4,
    parameter int SEL_W     = 2
) (
    input  opnd_class_e                  cls,
    input  logic [SEL_W-1:0]             wsel,
    input  logic [LIT_WORDS*WORD_W-1:0]  lit_words,
    input  logic [LIT_WORDS-1:0]         lit_ok,
    output logic [2*WORD_W-1:0]          val,
    output logic                         miss
);

    localparam int DATA_W = 2 * WORD_W;
    localparam int HALF_W = WORD_W / 2;

    logic [WORD_W-1:0] words  [LIT_WORDS];
    logic [DATA_W-1:0] lo_ext [LIT_WORDS];
    logic [DATA_W-1:0] hi_ext [LIT_WORDS];
    logic [SEL_W-1:0]  upper;

    for (genvar g = 0; g < LIT_WORDS; g++) begin : g_word
        assign words[g]  = lit_words[g*WORD_W +: WORD_W];
        assign lo_ext[g] = {{(DATA_W-HALF_W){words[g][HALF_W-1]}}, words[g][HALF_W-1:0]};
        assign hi_ext[g] = {{(DATA_W-HALF_W){words[g][WORD_W-1]}}, words[g][WORD_W-1:HALF_W]};
    end

    assign upper = wsel + SEL_W'(1);

    always_comb begin
        val  = '0;
        miss = 1'b0;
        unique case (cls)
            C_HALF_LO: begin
                miss = !lit_ok[wsel];
                val  = lo_ext[wsel];
            end
            C_HALF_HI: begin
                miss = !lit_ok[wsel];
                val  = hi_ext[wsel];
            end
            C_WORD: begin
                miss = !lit_ok[wsel];
                val  = {{(DATA_W-WORD_W){1'b0}}, words[wsel]};
            end
            C_PAIR: begin
                miss = !(lit_ok[wsel] && lit_ok[upper]);
                val  = {words[upper], words[wsel]};
            end
            default: begin
                val  = '0;
                miss = 1'b0;
            end
        endcase
        if (miss) begin
            val = '0;
        end
    end

endmodule

// File: rtl/opnd_src_resolver.sv
module opnd_src_resolver
    import opnd_src_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int LIT_WORDS = 4,
    parameter int CODE_W    = 8,
    parameter int IDX_W     = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [CODE_W-1:0]            src_code,
    input  logic [LIT_WORDS*WORD_W-1:0]  lit_words,
    input  logic [LIT_WORDS-1:0]         lit_ok,
    output logic                         rf_rd_en,
    output logic [2:0]                   rf_rd_kind,
    output logic [IDX_W-1:0]             rf_rd_idx,
    input  logic [2*WORD_W-1:0]          rf_rd_data,
    output logic                         out_valid,
    output logic [2*WORD_W-1:0]          out_data,
    output logic [2:0]                   out_kind,
    output logic [IDX_W-1:0]             out_idx,
    output logic                         out_err
);

    localparam int DATA_W = 2 * WORD_W;
    localparam int SEL_W  = $clog2(LIT_WORDS);
    localparam int CONST_W = 4;

    opnd_class_e      cls;
    opnd_kind_e       kind;
    logic [IDX_W-1:0] idx;
    logic [SEL_W-1:0] wsel;
    logic [DATA_W-1:0] lit_val;
    logic             lit_miss;

    opnd_src_classify #(
        .CODE_W (CODE_W),
        .IDX_W  (IDX_W),
        .SEL_W  (SEL_W)
    ) u_classify (
        .code (src_code),
        .cls  (cls),
        .kind (kind),
        .idx  (idx),
        .wsel (wsel)
    );

    opnd_src_literal #(
        .WORD_W    (WORD_W),
        .LIT_WORDS (LIT_WORDS),
        .SEL_W     (SEL_W)
    ) u_literal (
        .cls       (cls),
        .wsel      (wsel),
        .lit_words (lit_words),
        .lit_ok    (lit_ok),
        .val       (lit_val),
        .miss      (lit_miss)
    );

    // Register-file request in the strobe cycle.
    assign rf_rd_en   = in_valid && (cls == C_REG);
    assign rf_rd_kind = kind;
    assign rf_rd_idx  = idx;

    // Next result.
    logic              nxt_err;
    logic [DATA_W-1:0] nxt_data;
    opnd_kind_e        nxt_kind;
    logic [IDX_W-1:0]  nxt_idx;

    always_comb begin
        nxt_err  = 1'b0;
        nxt_data = '0;
        nxt_idx  = '0;
        unique case (cls)
            C_REG: begin
                nxt_data = rf_rd_data;
                nxt_idx  = idx;
            end
            C_CONST: nxt_data = {{(DATA_W-CONST_W){1'b0}}, src_code[CONST_W-1:0]};
            C_HALF_LO, C_HALF_HI, C_WORD, C_PAIR: begin
                nxt_err  = lit_miss;
                nxt_data = lit_val;
            end
            default: nxt_err = 1'b1;
        endcase
        nxt_kind = nxt_err ? K_BAD : kind;
    end

    // Output state machine.
    out_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_kind <= 3'(K_BAD);
            out_idx  <= '0;
            out_err  <= 1'b0;
        end else if (in_valid) begin
            out_data <= nxt_data;
            out_kind <= nxt_kind;
            out_idx  <= nxt_idx;
            out_err  <= nxt_err;
        end
    end

    assign out_valid = (state_q == ST_SHOW);

endmodule

// File: rtl/opnd_src_resolver_chk.sv
module opnd_src_resolver_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [7:0]  src_code,
    input logic        rf_rd_en,
    input logic        out_valid,
    input logic [63:0] out_data,
    input logic [2:0]  out_kind,
    input logic [6:0]  out_idx,
    input logic        out_err
);

    // R2
    r2_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    r2_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    r3_read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en |-> in_valid);

    // R4
    r4_glb_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 3'd2) |-> (out_idx < 7'd32));

    // R5
    r5_const_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 3'd3) |-> (out_data < 64'd16));

    // R9
    r9_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_data == 64'd0 && out_kind == 3'd7 && out_idx == 7'd0));

    // R9
    r9_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_code inside {8'hD2, 8'hD3, 8'hD6, 8'hD7, 8'hDF}) |-> !rf_rd_en);

    // R12
    r12_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind > 3'd2) |-> (out_idx == 7'd0));

endmodule

bind opnd_src_resolver opnd_src_resolver_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src_code  (src_code),
    .rf_rd_en  (rf_rd_en),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_kind  (out_kind),
    .out_idx   (out_idx),
    .out_err   (out_err)
);

// File: tb/opnd_src_resolver_tb.sv
module opnd_src_resolver_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   src_code = 8'h00;
    logic [127:0] lit_words;
    logic [3:0]   lit_ok = 4'hF;
    logic         rf_rd_en;
    logic [2:0]   rf_rd_kind;
    logic [6:0]   rf_rd_idx;
    logic [63:0]  rf_rd_data;
    logic         out_valid;
    logic [63:0]  out_data;
    logic [2:0]   out_kind;
    logic [6:0]   out_idx;
    logic         out_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] W0 = 32'h7FFF_8000;
    localparam logic [31:0] W1 = 32'h1234_F00D;
    localparam logic [31:0] W2 = 32'h8000_0001;
    localparam logic [31:0] W3 = 32'hCAFE_BABE;

    assign lit_words = {W3, W2, W1, W0};

    // Register-file model: data encodes bank and index.
    assign rf_rd_data = {32'h5EED_0000 | {29'd0, rf_rd_kind}, 25'd0, rf_rd_idx};

    always #10 clk = ~clk;

    opnd_src_resolver u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .src_code   (src_code),
        .lit_words  (lit_words),
        .lit_ok     (lit_ok),
        .rf_rd_en   (rf_rd_en),
        .rf_rd_kind (rf_rd_kind),
        .rf_rd_idx  (rf_rd_idx),
        .rf_rd_data (rf_rd_data),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_kind   (out_kind),
        .out_idx    (out_idx),
        .out_err    (out_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] reg_exp(input logic [2:0] k, input logic [6:0] i);
        return {32'h5EED_0000 | {29'd0, k}, 25'd0, i};
    endfunction

    // One strobe, then check request, result and the following idle cycle.
    task automatic run(input string req, input logic [7:0] c, input logic [3:0] ok,
                       input logic exp_rd, input logic [63:0] exp_data,
                       input logic [2:0] exp_kind, input logic [6:0] exp_idx,
                       input logic exp_err);
        @(negedge clk);
        src_code = c;
        lit_ok   = ok;
        in_valid = 1'b1;
        #1;
        chk({req, " rf_rd_en"}, 64'(rf_rd_en), 64'(exp_rd));
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " out_valid"}, 64'(out_valid), 64'd1);
        chk({req, " data"}, out_data, exp_data);
        chk({req, " kind"}, 64'(out_kind), 64'(exp_kind));
        chk({req, " idx"}, 64'(out_idx), 64'(exp_idx));
        chk({req, " err"}, 64'(out_err), 64'(exp_err));
        @(negedge clk);
        chk("R2 valid drops", 64'(out_valid), 64'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 out_err", 64'(out_err), 64'd0);
        chk("R1 out_data", out_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle without strobe", 64'(out_valid), 64'd0);
    endtask

    task automatic t_regs();
        run("R3 rot 00", 8'h00, 4'hF, 1'b1, reg_exp(3'd0, 7'h00), 3'd0, 7'h00, 1'b0);
        run("R3 rot 7F", 8'h7F, 4'hF, 1'b1, reg_exp(3'd0, 7'h7F), 3'd0, 7'h7F, 1'b0);
        run("R3 win 80", 8'h80, 4'hF, 1'b1, reg_exp(3'd1, 7'h00), 3'd1, 7'h00, 1'b0);
        run("R3 win BF", 8'hBF, 4'h0, 1'b1, reg_exp(3'd1, 7'h3F), 3'd1, 7'h3F, 1'b0);
        run("R4 glb E0", 8'hE0, 4'hF, 1'b1, reg_exp(3'd2, 7'h00), 3'd2, 7'h00, 1'b0);
        run("R4 glb FF", 8'hFF, 4'h0, 1'b1, reg_exp(3'd2, 7'h1F), 3'd2, 7'h1F, 1'b0);
    endtask

    task automatic t_const();
        run("R5 const C0", 8'hC0, 4'hF, 1'b0, 64'd0, 3'd3, 7'd0, 1'b0);
        run("R5 const C7", 8'hC7, 4'hF, 1'b0, 64'd7, 3'd3, 7'd0, 1'b0);
        run("R11 const CF no flags", 8'hCF, 4'h0, 1'b0, 64'd15, 3'd3, 7'd0, 1'b0);
        run("R11 rot no flags", 8'h15, 4'h0, 1'b1, reg_exp(3'd0, 7'h15), 3'd0, 7'h15, 1'b0);
    endtask

    task automatic t_half();
        run("R6 lo w0", 8'hD0, 4'hF, 1'b0, 64'hFFFF_FFFF_FFFF_8000, 3'd4, 7'd0, 1'b0);
        run("R6 lo w1", 8'hD1, 4'hF, 1'b0, 64'hFFFF_FFFF_FFFF_F00D, 3'd4, 7'd0, 1'b0);
        run("R6 hi w0", 8'hD4, 4'hF, 1'b0, 64'h0000_0000_0000_7FFF, 3'd4, 7'd0, 1'b0);
        run("R6 hi w1", 8'hD5, 4'hF, 1'b0, 64'h0000_0000_0000_1234, 3'd4, 7'd0, 1'b0);
    endtask

    task automatic t_word();
        run("R7 w0", 8'hD8, 4'hF, 1'b0, {32'd0, W0}, 3'd4, 7'd0, 1'b0);
        run("R7 w1", 8'hD9, 4'hF, 1'b0, {32'd0, W1}, 3'd4, 7'd0, 1'b0);
        run("R7 w2", 8'hDA, 4'hF, 1'b0, {32'd0, W2}, 3'd4, 7'd0, 1'b0);
        run("R7 w3", 8'hDB, 4'hF, 1'b0, {32'd0, W3}, 3'd4, 7'd0, 1'b0);
    endtask

    task automatic t_pair();
        run("R8 pair 10", 8'hDC, 4'hF, 1'b0, {W1, W0}, 3'd4, 7'd0, 1'b0);
        run("R8 pair 21", 8'hDD, 4'hF, 1'b0, {W2, W1}, 3'd4, 7'd0, 1'b0);
        run("R8 pair 32", 8'hDE, 4'hF, 1'b0, {W3, W2}, 3'd4, 7'd0, 1'b0);
    endtask

    task automatic t_bad();
        run("R9 D2", 8'hD2, 4'hF, 1'b0, 64'd0, 3'd7, 7'd0, 1'b1);
        run("R9 D3", 8'hD3, 4'hF, 1'b0, 64'd0, 3'd7, 7'd0, 1'b1);
        run("R9 D6", 8'hD6, 4'hF, 1'b0, 64'd0, 3'd7, 7'd0, 1'b1);
        run("R9 D7", 8'hD7, 4'hF, 1'b0, 64'd0, 3'd7, 7'd0, 1'b1);
        run("R9 DF", 8'hDF, 4'hF, 1'b0, 64'd0, 3'd7, 7'd0, 1'b1);
        // R12 index back to zero after a register result
        run("R12 after reg", 8'hA5, 4'hF, 1'b1, reg_exp(3'd1, 7'h25), 3'd1, 7'h25, 1'b0);
        run("R12 const idx", 8'hC3, 4'hF, 1'b0, 64'd3, 3'd3, 7'd0, 1'b0);
    endtask

    task automatic t_miss();
        run("R10 word1 absent", 8'hD9, 4'b1101, 1'b0, 64'd0, 3'd7, 7'd0, 1'b1);
        run("R10 half w0 absent", 8'hD4, 4'b1110, 1'b0, 64'd0, 3'd7, 7'd0, 1'b1);
        run("R10 pair upper absent", 8'hDE, 4'b0111, 1'b0, 64'd0, 3'd7, 7'd0, 1'b1);
        run("R10 pair lower absent", 8'hDC, 4'b1110, 1'b0, 64'd0, 3'd7, 7'd0, 1'b1);
        run("R10 other word absent", 8'hDD, 4'b1001, 1'b0, 64'd0, 3'd7, 7'd0, 1'b1);
        run("R10 unrelated absent", 8'hDA, 4'b0100, 1'b0, {32'd0, W2}, 3'd4, 7'd0, 1'b0);
    endtask

    task automatic t_back_to_back();
        // R2 two strobes in a row: both results appear on consecutive cycles
        @(negedge clk);
        lit_ok   = 4'hF;
        src_code = 8'hC9;
        in_valid = 1'b1;
        @(negedge clk);
        src_code = 8'hDB;
        chk("R2 b2b first valid", 64'(out_valid), 64'd1);
        chk("R2 b2b first data", out_data, 64'd9);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 b2b second valid", 64'(out_valid), 64'd1);
        chk("R7 b2b second data", out_data, {32'd0, W3});
        @(negedge clk);
        chk("R2 b2b drop", 64'(out_valid), 64'd0);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_const();
        t_half();
        t_word();
        t_pair();
        t_bad();
        t_miss();
        t_back_to_back();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule